// File: doc/BRIEF.md
# Precise exception tracker for an in-order five-stage pipeline

This block follows every instruction in flight through the decode, execute, memory and write-back slots of an in-order pipeline. Each slot keeps the instruction's PC and a status vector. The vector holds one field per stage that can raise a fault: fetch, decode, execute and memory. When the fetch, decode, execute or memory logic detects a fault for the instruction it holds, it posts a bit in its own field. The bit stays in the vector and moves down the pipeline with that instruction.

A posted fault is only acted on when the instruction sits in write-back. While a fault is pending, the block drives a write-kill mask that blocks state updates for the faulting instruction and for every younger instruction. When the write-back instruction carries any fault, the block raises a trap and asks fetch to redirect to a fixed handler address. In the same cycle it records a cause code and the restart PCs, and it empties every slot. Because only write-back is inspected, an older instruction's faults are always taken before a younger one's, even when the younger one faulted first.

Top module: `precise_trap_unit`

## Requirements
- R1: After reset all slots are empty: `trap_o`, `redirect_o` and `kill_o` are 0, and `cause_o` and `epc_o` are 0.
- R2: A fault bit posted for an instruction travels with it. `trap_o` rises in the cycle in which that instruction is in write-back, and not earlier.
- R3: When `adv_i` is 0 every slot holds its instruction. Fault bits posted during such cycles are kept and are OR-ed with any later ones.
- R4: `kill_o` bit order is 0 = decode, 1 = execute, 2 = memory, 3 = write-back. A bit is 1 when that slot, or any older slot, holds a valid instruction whose status is non-zero. This includes bits posted in the current cycle.
- R5: `exc_i` has four fields of FLD_W bits: fetch at bits [FLD_W-1:0], then decode, execute and memory at higher positions. The cause is the lowest set bit of the write-back vector, so an earlier stage wins over a later one, and a lower bit wins inside a stage. The code is field*FLD_W + bit.
- R6: When several instructions carry faults, only the oldest traps. Younger instructions are discarded without a trap of their own.
- R7: In a trap cycle `redirect_o` is 1 and `handler_pc_o` equals HANDLER_PC. In the next cycle every slot is empty, and the fetched instruction of the trap cycle is dropped.
- R8: At a trap, `epc_o` entry k (bits k*PC_W and up) takes the PC of the k-th oldest slot (write-back first), or 0 if that slot is empty. Entry k = 1 gives the second PC needed to restart after a one-instruction branch delay. `epc_o` and `cause_o` hold until the next trap.
- R9: Fault bits posted for an empty slot, or for a fetch with `fetch_vld_i` at 0, are ignored. Each stage only affects its own field.
- R10: A faulting write-back instruction raises `trap_o` whether `adv_i` is 1 or 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Pipeline advances one stage at this edge |
| fetch_vld_i | input | 1 | Fetch stage holds a real instruction |
| fetch_pc_i | input | PC_W | PC of the fetched instruction |
| exc_i | input | 4*FLD_W | Fault bits posted this cycle, one field per posting stage |
| kill_o | output | 4 | Write-kill per slot (decode, execute, memory, write-back) |
| trap_o | output | 1 | Trap taken this cycle |
| redirect_o | output | 1 | Fetch must load the handler address |
| handler_pc_o | output | PC_W | Handler vector address |
| cause_o | output | $clog2(4*FLD_W) | Cause code of the last trap |
| epc_o | output | N_SAVE*PC_W | Restart PCs of the last trap, oldest in the low entry |

## Verification
The block is driven with four kinds of patterns:
- Clean streams with no faults. These show that nothing traps and nothing is killed.
- Single faults raised at each stage. These show how the fault travels and when the trap arrives.
- Two faults in one instruction, and a younger instruction that faults before an older one. These separate priority inside one instruction from ordering between instructions.
- Stalls with posts made during the hold, posts into empty slots, and a long random stream with random advance, fetch and fault bits. These show that stalled faults are kept, that empty-slot posts are ignored, and that flushes and saved PCs stay right in every combination.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
    // posting stages, in age order of the fault inside one instruction
    localparam int NFIELD   = 4;   // fetch, decode, execute, memory
    localparam int FLD_FE   = 0;
    // tracked slots: decode, execute, memory, write-back
    localparam int NSLOT    = 4;
    localparam int SLOT_WB  = 3;
endpackage

// File: rtl/ptu_slot.sv
// One pipeline slot: valid, PC and sticky status vector of its instruction.
module ptu_slot #(
    parameter int PC_W = 32,
    parameter int ST_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_i,
    input  logic            flush_i,
    input  logic            in_vld_i,
    input  logic [PC_W-1:0] in_pc_i,
    input  logic [ST_W-1:0] in_st_i,
    input  logic [ST_W-1:0] post_i,
    output logic            vld_o,
    output logic [PC_W-1:0] pc_o,
    output logic [ST_W-1:0] st_o
);
    typedef struct packed {
        logic            vld;
        logic [PC_W-1:0] pc;
        logic [ST_W-1:0] st;
    } ent_t;

    ent_t ent_q, ent_d;
    logic [ST_W-1:0] eff_st;

    assign eff_st = ent_q.vld ? (ent_q.st | post_i) : '0;

    always_comb begin
        ent_d    = ent_q;
        ent_d.st = eff_st;
        if (flush_i) begin
            ent_d = '0;
        end else if (adv_i) begin
            ent_d.vld = in_vld_i;
            ent_d.pc  = in_pc_i;
            ent_d.st  = in_vld_i ? in_st_i : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign vld_o = ent_q.vld;
    assign pc_o  = ent_q.pc;
    assign st_o  = eff_st;
endmodule

// File: rtl/ptu_prio.sv
// Lowest set bit wins: earlier stage field first, then lower bit.
module ptu_prio #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/ptu_kill.sv
// A pending fault kills its own slot and every younger slot.
module ptu_kill #(
    parameter int N = 4
) (
    input  logic [N-1:0] fault_i,
    output logic [N-1:0] kill_o
);
    assign kill_o[N-1] = fault_i[N-1];
    for (genvar s = 0; s < N - 1; s++) begin : g_chain
        assign kill_o[s] = fault_i[s] | kill_o[s+1];
    end
endmodule

// File: rtl/precise_trap_unit.sv
module precise_trap_unit
    import ptu_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter int              FLD_W      = 2,
    parameter int              N_SAVE     = 2,
    parameter logic [PC_W-1:0] HANDLER_PC = 'h80,
    localparam int             ST_W       = NFIELD * FLD_W,
    localparam int             CW         = $clog2(ST_W)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adv_i,
    input  logic                   fetch_vld_i,
    input  logic [PC_W-1:0]        fetch_pc_i,
    input  logic [ST_W-1:0]        exc_i,
    output logic [NSLOT-1:0]       kill_o,
    output logic                   trap_o,
    output logic                   redirect_o,
    output logic [PC_W-1:0]        handler_pc_o,
    output logic [CW-1:0]          cause_o,
    output logic [N_SAVE*PC_W-1:0] epc_o
);
    localparam logic [ST_W-1:0] FMASK = ST_W'({FLD_W{1'b1}});

    typedef struct packed {
        logic [CW-1:0]                cause;
        logic [N_SAVE-1:0][PC_W-1:0] epc;
    } cap_t;

    logic [NSLOT-1:0]       s_vld;
    logic [PC_W-1:0]        s_pc   [NSLOT];
    logic [ST_W-1:0]        s_st   [NSLOT];
    logic [ST_W-1:0]        s_post [NSLOT];
    logic [NSLOT-1:0]       fault;
    logic [ST_W-1:0]        fetch_st;
    logic [CW-1:0]          wb_idx;
    logic                   take;
    cap_t                   cap_q, cap_d;

    assign fetch_st = fetch_vld_i ? (exc_i & (FMASK << (FLD_FE * FLD_W))) : '0;

    for (genvar gs = 0; gs < NSLOT; gs++) begin : g_slot
        logic            in_vld;
        logic [PC_W-1:0] in_pc;
        logic [ST_W-1:0] in_st;

        if (gs == 0) begin : g_head
            assign in_vld = fetch_vld_i;
            assign in_pc  = fetch_pc_i;
            assign in_st  = fetch_st;
        end else begin : g_body
            assign in_vld = s_vld[gs-1];
            assign in_pc  = s_pc[gs-1];
            assign in_st  = s_st[gs-1];
        end

        if (gs < SLOT_WB) begin : g_post
            assign s_post[gs] = exc_i & (FMASK << ((gs + 1) * FLD_W));
        end else begin : g_nopost
            assign s_post[gs] = '0;
        end

        ptu_slot #(.PC_W(PC_W), .ST_W(ST_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv_i    (adv_i),
            .flush_i  (take),
            .in_vld_i (in_vld),
            .in_pc_i  (in_pc),
            .in_st_i  (in_st),
            .post_i   (s_post[gs]),
            .vld_o    (s_vld[gs]),
            .pc_o     (s_pc[gs]),
            .st_o     (s_st[gs])
        );

        assign fault[gs] = |s_st[gs];
    end

    ptu_kill #(.N(NSLOT)) u_kill (
        .fault_i (fault),
        .kill_o  (kill_o)
    );

    ptu_prio #(.W(ST_W), .IW(CW)) u_prio (
        .vec_i (s_st[SLOT_WB]),
        .idx_o (wb_idx)
    );

    assign take = fault[SLOT_WB];

    always_comb begin
        cap_d = cap_q;
        if (take) begin
            cap_d.cause = wb_idx;
            for (int k = 0; k < N_SAVE; k++) begin
                cap_d.epc[k] = s_vld[SLOT_WB-k] ? s_pc[SLOT_WB-k] : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign trap_o       = take;
    assign redirect_o   = take;
    assign handler_pc_o = HANDLER_PC;
    assign cause_o      = cap_q.cause;
    assign epc_o        = cap_q.epc;
endmodule

// File: rtl/ptu_check.sv
module ptu_check #(
    parameter int PC_W   = 32,
    parameter int N_SAVE = 2,
    parameter int NK     = 4,
    parameter int CW     = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   trap_o,
    input logic [NK-1:0]          kill_o,
    input logic [CW-1:0]          cause_o,
    input logic [N_SAVE*PC_W-1:0] epc_o
);
    // a taken trap empties write-back, so no trap follows directly
    p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> !trap_o);

    // the trapping instruction itself has its writes killed
    p_wb_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> kill_o[NK-1]);

    // a kill in an older slot always covers the younger slots
    for (genvar s = 0; s < NK - 1; s++) begin : g_mono
        p_kill_young_r4: assert property (@(posedge clk) disable iff (!rst_n)
            kill_o[s+1] |-> kill_o[s]);
    end

    // saved restart state only changes after a trap
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |=> ($stable(epc_o) && $stable(cause_o)));
endmodule

bind precise_trap_unit ptu_check #(
    .PC_W(PC_W), .N_SAVE(N_SAVE), .NK(ptu_pkg::NSLOT), .CW(CW)
) u_ptu_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .trap_o  (trap_o),
    .kill_o  (kill_o),
    .cause_o (cause_o),
    .epc_o   (epc_o)
);

// File: tb/precise_trap_unit_bench.sv
module precise_trap_unit_bench;
    localparam int PC_W = 32;
    localparam int FW   = 2;
    localparam int SW   = 8;
    localparam int NS   = 2;
    localparam logic [31:0] HPC = 32'h80;

    typedef struct {
        int pc;
        int st;
        int stg;   // 0 decode, 1 execute, 2 memory, 3 write-back
    } rec_t;

    logic clk = 0;
    logic rst_n = 0;
    logic adv = 0, fvld = 0;
    logic [31:0] fpc = 0;
    logic [7:0]  exc = 0;
    logic [3:0]  kill;
    logic        trap, redir;
    logic [31:0] hpc;
    logic [2:0]  cause;
    logic [63:0] epc;

    int checks = 0, errors = 0;
    rec_t q[$];
    int m_cause = 0;
    logic [63:0] m_epc = 0;

    always #5 clk = ~clk;

    precise_trap_unit u_precise_trap_unit (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .fetch_vld_i(fvld),
        .fetch_pc_i(fpc), .exc_i(exc), .kill_o(kill), .trap_o(trap),
        .redirect_o(redir), .handler_pc_o(hpc), .cause_o(cause), .epc_o(epc)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int fmask(int f);
        return 3 << (f * FW);
    endfunction

    task automatic step(bit a, bit fv, int pc, int e, string tag);
        int eff[$];
        bit trap_e;
        logic [3:0] kill_e;
        @(negedge clk);
        adv = a; fvld = fv; fpc = pc; exc = e[7:0];
        #1;
        eff.delete();
        foreach (q[i]) eff.push_back(q[i].st | (q[i].stg < 3 ? (e & fmask(q[i].stg + 1)) : 0));
        trap_e = (q.size() > 0) && (q[0].stg == 3) && (eff[0] != 0);
        kill_e = '0;
        for (int s = 0; s < 4; s++)
            foreach (q[i]) if (q[i].stg >= s && eff[i] != 0) kill_e[s] = 1'b1;
        chk(tag, "trap", trap, trap_e);
        chk(tag, "redirect R7", redir, trap_e);
        chk(tag, "handler R7", hpc, HPC);
        chk(tag, "kill R4", kill, kill_e);
        chk(tag, "cause R5", cause, m_cause);
        chk(tag, "epc R8", epc, m_epc);
        @(posedge clk);
        if (trap_e) begin
            m_cause = 0;
            for (int b = SW - 1; b >= 0; b--) if (eff[0][b]) m_cause = b;
            m_epc = 0;
            for (int k = 0; k < NS; k++)
                foreach (q[i]) if (q[i].stg == 3 - k) m_epc[k*PC_W +: PC_W] = q[i].pc;
            q.delete();
        end else begin
            foreach (q[i]) q[i].st = eff[i];
            if (a) begin
                foreach (q[i]) q[i].stg++;
                while (q.size() > 0 && q[0].stg > 3) void'(q.pop_front());
                if (fv) q.push_back('{pc, e & fmask(0), 0});
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        step(0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, "R1");
        // clean stream
        for (int i = 0; i < 6; i++) step(1, 1, 32'h100 + 4*i, 0, "R2");
        // single execute fault travelling to write-back
        step(1, 1, 32'h200, 0, "R2");
        step(1, 1, 32'h204, 0, "R2");
        step(1, 1, 32'h208, 8'h10, "R2");   // 0x200 in execute
        for (int i = 0; i < 4; i++) step(1, 1, 32'h20c + 4*i, 0, "R2");
        // younger fetch fault before older memory fault
        step(1, 1, 32'h300, 0, "R6");
        step(1, 1, 32'h304, 8'h01, "R6");   // 0x304 fetch fault
        step(1, 1, 32'h308, 0, "R6");
        step(1, 1, 32'h30c, 8'h80, "R6");   // 0x300 memory fault
        for (int i = 0; i < 4; i++) step(1, 1, 32'h310 + 4*i, 0, "R6");
        // two faults in one instruction
        step(1, 1, 32'h400, 8'h02, "R5");
        step(1, 1, 32'h404, 0, "R5");
        step(1, 1, 32'h408, 8'h11, "R5");
        for (int i = 0; i < 4; i++) step(1, 1, 32'h40c + 4*i, 0, "R5");
        // stall with a decode post, then trap while stalled
        step(1, 1, 32'h500, 0, "R3");
        step(0, 1, 32'h504, 8'h04, "R3");
        step(0, 1, 32'h504, 0, "R3");
        step(0, 1, 32'h504, 8'h08, "R3");
        step(1, 1, 32'h504, 0, "R3");
        step(1, 1, 32'h508, 0, "R3");
        step(1, 1, 32'h50c, 0, "R10");
        step(0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, "R10");
        // posts into empty slots and invalid fetch
        step(1, 0, 32'h600, 8'hff, "R9");
        step(1, 0, 0, 8'hfe, "R9");
        step(1, 1, 32'h604, 8'h0c, "R9");
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R9");
        // random stream
        for (int i = 0; i < 3000; i++) begin
            int e;
            e = ($urandom_range(0, 19) == 0) ? (1 << $urandom_range(0, 7)) : 0;
            step($urandom_range(0, 4) != 0, $urandom_range(0, 4) != 0,
                 32'h1000 + 4*i, e, "R6");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule